// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Bank

This block keeps the digital codes for a four-channel, 16-bit voltage DAC. Every channel owns two registers: a staging register that commands write into, and an active register whose value goes to the converter. Commands come from a serial front end that has already assembled each frame. A frame carries an opcode, a one-hot-per-bit channel mask and a 16-bit data word. Staged codes reach the active registers in one of three ways: an update command, a combined write-and-update command, or a transfer strobe. The strobe can be pulsed to move all pending channels at the same instant. It can also be held low, and then each write goes straight through to the active register.

A clear pin loads both registers of every channel with a default value when it falls. The default is zero scale or midscale, chosen by a select pin, and the same default is applied at power-on. Each channel also has its own power-down flag. A readback command returns one staging register on a small output stream. Every input is synchronous to `clk`. The converter, gain and span control and the serial shifter are outside this block.

Command stream rules: a frame is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while the clear pin is low, and also while a readback word is waiting to be taken. A frame that is not taken has no effect, and the sender must hold it. The readback stream holds `rd_valid` and `rd_data` steady until an edge where `rd_ready` is high.

Top module: `dac_code_bank`

## Requirements
- R1: After power-on reset (`rst_n` low for at least one edge), every channel's active code is 0x0000 when `mid_sel`=0 and 0x8000 when `mid_sel`=1. All `pd_out` bits are 0 and `rd_valid` is 0.
- R2: Opcode 0x1 with `xfer_n` high writes `cmd_data` into the staging register of each channel whose mask bit is set (bit i selects channel i; channel i's code is `code_out[16*i+15:16*i]`). It leaves active codes unchanged and marks those channels pending.
- R3: On a falling edge of `xfer_n` while `clr_n` is high, every pending channel copies its staging register into its active register one cycle later, and its pending mark is cleared. Channels that are not pending keep their codes, so a second edge with no new writes changes nothing. Active codes change only through R3, R4, R5, R6 and R10.
- R4: When opcode 0x1 is taken while `xfer_n` is low, each selected channel's active register is loaded with `cmd_data` as well, and that channel is not left pending.
- R5: Opcode 0x2 copies the staging register into the active register for each selected channel and clears its pending mark.
- R6: Opcode 0x3 loads `cmd_data` into both registers of each selected channel and clears its pending mark.
- R7: Opcode 0x4 sets `pd_out[i]` to 1 when `cmd_data[2i+1:2i]` is not 00 and to 0 when it is 00. It ignores the channel mask and leaves codes unchanged. `pd_out` changes by no other command.
- R8: Opcode 0x9 puts the staging register of the lowest-numbered selected channel (0x0000 when the mask is empty) on `rd_data`, with `rd_valid` high from the next cycle. Both hold until an edge with `rd_ready` high.
- R9: `cmd_ready` is low while `clr_n` is low or `rd_valid` is high, and a frame offered then has no effect.
- R10: A falling edge of `clr_n` loads the R1 default into both registers of every channel, clears every pending mark and power-down flag one cycle later. While `clr_n` stays low, codes and flags hold and `xfer_n` edges are ignored.
- R11: Opcodes 0x0, 0x5 to 0x8 and 0xA to 0xF are taken and change no register and no pending mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| mid_sel | input | 1 | Default select: 0 zero scale, 1 midscale |
| clr_n | input | 1 | Clear pin, acts on its falling edge, blocks while low |
| xfer_n | input | 1 | Transfer strobe, active low; pulsed or held low |
| cmd_valid | input | 1 | Command frame present |
| cmd_ready | output | 1 | Command frame can be taken |
| cmd_op | input | 4 | Opcode |
| cmd_sel | input | 4 | Channel mask, bit i for channel i |
| cmd_data | input | 16 | Code or power-down field |
| rd_valid | output | 1 | Readback word present |
| rd_ready | input | 1 | Readback word taken |
| rd_data | output | 16 | Readback word |
| code_out | output | 64 | Active codes, channel i at bits 16i+15:16i |
| pd_out | output | 4 | Per-channel power-down flags |

## Verification
The writes are tried with all sixteen channel masks, under both default selections. Their data is derived from the mask, so a wrong channel wiring or a stray update shows up as a wrong code. Transfer pulses after partial writes, and a repeated pulse, separate pending channels from idle ones. Holding the strobe low during the same sweeps separates the pass-through mode from the staged mode. All 256 power-down fields are applied with an empty mask, to show that the mask plays no part. Readback is tried with all sixteen masks to check that the lowest channel wins. Clear edges, strobes during clear, reserved opcodes and a stalled readback show that blocked or ignored inputs leave the state alone.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int OP_W   = 4;
  localparam int PD_FLD = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'h0,
    OP_WR_IN  = 4'h1,
    OP_UPD    = 4'h2,
    OP_WR_UPD = 4'h3,
    OP_PWR    = 4'h4,
    OP_RDSEL  = 4'h9
  } op_e;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                    acc,
  input  logic [OP_W-1:0]         op,
  input  logic [NCH-1:0]          sel,
  input  logic [PD_FLD*NCH-1:0]   pd_field,
  input  logic                    xfer_low,
  output logic [NCH-1:0]          wr_in,
  output logic [NCH-1:0]          ld_data,
  output logic [NCH-1:0]          ld_in,
  output logic                    pd_we,
  output logic [NCH-1:0]          pd_new,
  output logic                    rd_req
);
  logic is_wr, is_wrupd, is_upd;

  always_comb begin
    is_wr    = acc && (op == OP_WR_IN);
    is_wrupd = acc && (op == OP_WR_UPD);
    is_upd   = acc && (op == OP_UPD);
    pd_we    = acc && (op == OP_PWR);
    rd_req   = acc && (op == OP_RDSEL);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_in[i]   = sel[i] && (is_wr || is_wrupd);
    assign ld_data[i] = sel[i] && (is_wrupd || (is_wr && xfer_low));
    assign ld_in[i]   = sel[i] && is_upd;
    assign pd_new[i]  = |pd_field[PD_FLD*i +: PD_FLD];
  end
endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] dflt,
  input  logic          clr_ld,
  input  logic          wr_in,
  input  logic          ld_data,
  input  logic          ld_in,
  input  logic          xfer_edge,
  input  logic [CW-1:0] data,
  input  logic          pd_we,
  input  logic          pd_new,
  output logic [CW-1:0] stage_q,
  output logic [CW-1:0] act_q,
  output logic          pd_q
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_ld) begin
      stage_q <= dflt;
      act_q   <= dflt;
      pend_q  <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      if (wr_in) stage_q <= data;

      if (ld_data)                 act_q <= data;
      else if (ld_in)              act_q <= stage_q;
      else if (xfer_edge && pend_q) act_q <= stage_q;

      if (ld_data || ld_in) pend_q <= 1'b0;
      else if (wr_in)       pend_q <= 1'b1;
      else if (xfer_edge)   pend_q <= 1'b0;

      if (pd_we) pd_q <= pd_new;
    end
  end
endmodule

// File: rtl/dac_readback.sv
module dac_readback #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [NCH-1:0]    sel,
  input  logic [NCH*CW-1:0] stage_all,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [CW-1:0]     rd_data
);
  logic [CW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (sel[i]) pick = stage_all[i*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_req) begin
      rd_valid <= 1'b1;
      rd_data  <= pick;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
  import dac_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_sel,
  input  logic              clr_n,
  input  logic              xfer_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [NCH-1:0]    cmd_sel,
  input  logic [CW-1:0]     cmd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [CW-1:0]     rd_data,
  output logic [NCH*CW-1:0] code_out,
  output logic [NCH-1:0]    pd_out
);
  localparam int PDW = PD_FLD * NCH;

  logic              clr_q, xfer_q;
  logic              clr_fall, xfer_edge, acc;
  logic [CW-1:0]     dflt;
  logic [NCH-1:0]    wr_in, ld_data, ld_in, pd_new;
  logic              pd_we, rd_req;
  logic [NCH*CW-1:0] stage_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_q  <= 1'b1;
      xfer_q <= 1'b1;
    end else begin
      clr_q  <= clr_n;
      xfer_q <= xfer_n;
    end
  end

  always_comb begin
    clr_fall  = clr_q && !clr_n;
    xfer_edge = xfer_q && !xfer_n && clr_n;
    cmd_ready = clr_n && !rd_valid;
    acc       = cmd_valid && cmd_ready;
    dflt      = mid_sel ? CW'(1) << (CW - 1) : '0;
  end

  dac_cmd_decode #(.NCH(NCH)) u_dec (
    .acc      (acc),
    .op       (cmd_op),
    .sel      (cmd_sel),
    .pd_field (cmd_data[PDW-1:0]),
    .xfer_low (!xfer_n),
    .wr_in    (wr_in),
    .ld_data  (ld_data),
    .ld_in    (ld_in),
    .pd_we    (pd_we),
    .pd_new   (pd_new),
    .rd_req   (rd_req)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_slice
    dac_chan_slice #(.CW(CW)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .dflt      (dflt),
      .clr_ld    (clr_fall),
      .wr_in     (wr_in[i]),
      .ld_data   (ld_data[i]),
      .ld_in     (ld_in[i]),
      .xfer_edge (xfer_edge),
      .data      (cmd_data),
      .pd_we     (pd_we),
      .pd_new    (pd_new[i]),
      .stage_q   (stage_all[i*CW +: CW]),
      .act_q     (code_out[i*CW +: CW]),
      .pd_q      (pd_out[i])
    );
  end

  dac_readback #(.NCH(NCH), .CW(CW)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .sel       (cmd_sel),
    .stage_all (stage_all),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk
  import dac_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mid_sel,
  input logic              clr_n,
  input logic              xfer_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [OP_W-1:0]   cmd_op,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [CW-1:0]     rd_data,
  input logic [NCH*CW-1:0] code_out,
  input logic [NCH-1:0]    pd_out
);
  logic              clr_seen_q;
  logic [NCH*CW-1:0] dflt_all_q;
  logic              taken;

  always_ff @(posedge clk) begin
    if (!rst_n) clr_seen_q <= 1'b1;
    else        clr_seen_q <= clr_n;
    dflt_all_q <= {NCH{mid_sel ? CW'(1) << (CW - 1) : CW'(0)}};
  end

  assign taken = cmd_valid && cmd_ready;

  // R10
  clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_seen_q && !clr_n) |=> (code_out == dflt_all_q) && (pd_out == '0));

  // R10
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_seen_q && !clr_n) |=> $stable(code_out) && $stable(pd_out));

  // R9
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n || rd_valid) |-> !cmd_ready);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data));

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !(taken && cmd_op == OP_PWR)) |=> $stable(pd_out));

  // R3
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && xfer_n && !(taken && (cmd_op == OP_UPD || cmd_op == OP_WR_UPD)))
      |=> $stable(code_out));
endmodule

bind dac_code_bank dac_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mid_sel   (mid_sel),
  .clr_n     (clr_n),
  .xfer_n    (xfer_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .code_out  (code_out),
  .pd_out    (pd_out)
);

// File: tb/test_dac_code_bank.sv
module test_dac_code_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, mid_sel = 1'b0, clr_n = 1'b1, xfer_n = 1'b1;
  logic cmd_valid = 1'b0, rd_ready = 1'b1;
  logic [3:0] cmd_op = '0;
  logic [NCH-1:0] cmd_sel = '0;
  logic [CW-1:0] cmd_data = '0;
  logic cmd_ready, rd_valid;
  logic [CW-1:0] rd_data;
  logic [NCH*CW-1:0] code_out;
  logic [NCH-1:0] pd_out;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [CW-1:0] m_in [NCH];
  logic [CW-1:0] m_act[NCH];
  bit m_pend[NCH];
  bit m_pd[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_code_bank #(.NCH(NCH), .CW(CW)) i_dac_code_bank (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .clr_n(clr_n), .xfer_n(xfer_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .code_out(code_out), .pd_out(pd_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [CW-1:0] dflt();
    return mid_sel ? 16'h8000 : 16'h0000;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < NCH; i++) begin
      m_in[i] = dflt(); m_act[i] = dflt(); m_pend[i] = 0; m_pd[i] = 0;
    end
  endtask

  task automatic check_state(input string req);
    for (int i = 0; i < NCH; i++) begin
      chk(code_out[i*CW +: CW] == m_act[i], req, code_out[i*CW +: CW], m_act[i]);
      chk(pd_out[i] == m_pd[i], req, pd_out[i], m_pd[i]);
    end
  endtask

  // drive a frame that is known to be accepted, then update the model
  task automatic send(input logic [3:0] op, input logic [3:0] sel,
                      input logic [CW-1:0] data);
    cmd_valid = 1; cmd_op = op; cmd_sel = sel; cmd_data = data;
    tick();
    cmd_valid = 0;
    for (int i = 0; i < NCH; i++) begin
      if (sel[i]) begin
        case (op)
          4'h1: begin
            m_in[i] = data;
            if (!xfer_n) begin m_act[i] = data; m_pend[i] = 0; end
            else m_pend[i] = 1;
          end
          4'h2: begin m_act[i] = m_in[i]; m_pend[i] = 0; end
          4'h3: begin m_in[i] = data; m_act[i] = data; m_pend[i] = 0; end
          default: ;
        endcase
      end
      if (op == 4'h4) m_pd[i] = (data[2*i +: 2] != 2'b00);
    end
  endtask

  task automatic set_xfer(input logic v);
    logic old = xfer_n;
    xfer_n = v;
    tick();
    if (old && !v && clr_n)
      for (int i = 0; i < NCH; i++)
        if (m_pend[i]) begin m_act[i] = m_in[i]; m_pend[i] = 0; end
  endtask

  task automatic readback(input logic [3:0] sel);
    logic [CW-1:0] exp = '0;
    for (int i = NCH - 1; i >= 0; i--) if (sel[i]) exp = m_in[i];
    send(4'h9, sel, 16'hFFFF);
    chk(rd_valid == 1'b1, "R8 valid", rd_valid, 1);
    chk(rd_data == exp, "R8 data", rd_data, exp);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int ms = 0; ms < 2; ms++) begin
      @(negedge clk);
      mid_sel = ms[0]; rst_n = 0; clr_n = 1; xfer_n = 1; rd_ready = 1;
      repeat (3) tick();
      rst_n = 1;
      tick();
      model_defaults();
      check_state("R1 reset");
      chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);

      // R2 staged writes with every mask, R3 transfer every four masks
      for (int m = 0; m < 16; m++) begin
        send(4'h1, m[3:0], 16'h1357 * (m + 1) + 16'(ms));
        check_state("R2 staged write");
        if (m % 4 == 3) begin
          set_xfer(0); check_state("R3 transfer");
          set_xfer(1);
          set_xfer(0); check_state("R3 second edge");
          set_xfer(1);
        end
      end

      // R8 readback all masks
      send(4'h3, 4'hF, 16'h0);
      for (int i = 0; i < NCH; i++) send(4'h1, 4'(1 << i), 16'hA000 + 16'(i * 16'h0111));
      for (int m = 0; m < 16; m++) readback(m[3:0]);

      // R5 update command per mask
      for (int m = 0; m < 16; m++) begin
        send(4'h1, 4'hF, 16'h2468 + 16'(m * 16'h0F0F));
        send(4'h2, m[3:0], 16'hDEAD);
        check_state("R5 update");
        set_xfer(0); check_state("R5 pending after update");
        set_xfer(1);
      end

      // R6 write and update
      for (int m = 0; m < 16; m++) begin
        send(4'h3, m[3:0], 16'hC001 ^ 16'(m << 8));
        check_state("R6 write-update");
      end

      // R4 strobe held low
      send(4'h1, 4'h5, 16'h7777);
      set_xfer(0);
      check_state("R4 entry");
      for (int m = 0; m < 16; m++) begin
        send(4'h1, m[3:0], 16'h4000 + 16'(m * 16'h0321));
        check_state("R4 pass-through");
      end
      set_xfer(1);

      // R7 every power-down field, empty mask
      for (int f = 0; f < 256; f++) begin
        send(4'h4, 4'h0, 16'(f) | 16'hFF00);
        check_state("R7 power-down");
      end

      // R11 reserved and no-op opcodes
      send(4'h1, 4'hA, 16'h5A5A);
      for (int op = 0; op < 16; op++) begin
        if (op >= 1 && op <= 4) continue;
        if (op == 9) continue;
        send(4'(op), 4'hF, 16'hFFFF);
        check_state("R11 ignored opcode");
      end
      set_xfer(0); check_state("R11 pending intact");
      set_xfer(1);

      // R9 stalled readback blocks commands
      rd_ready = 0;
      send(4'h9, 4'h2, 16'h0);
      chk(rd_valid == 1 && rd_data == m_in[1], "R8 stalled data", rd_data, m_in[1]);
      cmd_valid = 1; cmd_op = 4'h3; cmd_sel = 4'hF; cmd_data = 16'hBEEF;
      repeat (3) tick();
      chk(cmd_ready == 0, "R9 ready while rd_valid", cmd_ready, 0);
      chk(rd_valid == 1, "R8 held", rd_valid, 1);
      check_state("R9 blocked frame");
      cmd_valid = 0; rd_ready = 1;
      tick();
      chk(rd_valid == 0, "R8 drained", rd_valid, 0);

      // R10 clear edge, strobes and frames while low
      send(4'h1, 4'h3, 16'h9999);
      send(4'h4, 4'h0, 16'h00C3);
      clr_n = 0;
      tick();
      model_defaults();
      check_state("R10 clear load");
      chk(cmd_ready == 0, "R9 ready while clear", cmd_ready, 0);
      cmd_valid = 1; cmd_op = 4'h3; cmd_sel = 4'hF; cmd_data = 16'h1234;
      xfer_n = 0; tick(); xfer_n = 1; tick(); xfer_n = 0; tick();
      cmd_valid = 0;
      check_state("R10 hold while low");
      xfer_n = 1; tick();
      clr_n = 1; tick();
      check_state("R10 release");
      readback(4'h1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule